// File: doc/BRIEF.md
# USB Control Endpoint SETUP Receive Sequencer

This block runs the device-side SETUP stage of USB control endpoints. A decoded token (kind plus endpoint number) arrives from the packet layer. For a SETUP token, eight payload bytes follow. The block packs each finished SETUP packet into three 32-bit words on a write port into a shared receive FIFO. It never looks at free space or at the endpoint's NAK state while doing so.

For each endpoint the block keeps a small SETUP counter that software loads. The counter drops by one per accepted packet, so software can tell how many packets arrived. A finished packet forces both NAK flags of its endpoint. The first IN or OUT token to that endpoint ends the stage. At that point one stage-done word is written and the OUT endpoint enable is dropped. The block also watches the application pop port. Only when the application pops the stage-done word does the per-endpoint SETUP interrupt flag rise.

Top module: `usb_setup_rx_seq`

## Requirements
- R1: Each endpoint has a 2-bit SETUP counter, readable on `setup_cnt` (endpoint e in bits [2e+1:2e]). It resets to 0, is loaded through `cnt_wr_en`/`cnt_wr_val`, and is decremented by one on the clock edge that accepts the eighth payload byte.
- R2: A SETUP packet is accepted even if the counter was never loaded. The decrement then wraps modulo 4 (0 becomes 3).
- R3: After the edge that takes the eighth byte, `fifo_wr_en` is high for exactly three consecutive cycles. The words are the status word, then payload bytes 0..3 as {b3,b2,b1,b0}, then bytes 4..7 as {b7,b6,b5,b4}.
- R4: Status word layout: endpoint in [3:0], byte count in [14:4], packet code in [20:17], all other bits 0. SETUP data uses count 8 and code 4'h6. Stage-done uses count 0 and code 4'h4.
- R5: An accepted SETUP packet sets both `in_nak` and `out_nak` of its endpoint in the same cycle the status word appears. The flags hold until cleared through `nak_in_clr`/`nak_out_clr`. A set wins over a clear in the same cycle.
- R6: A SETUP packet is accepted and written whatever the endpoint's NAK flags are.
- R7: The first IN or OUT token to an endpoint with a SETUP packet pending produces exactly one stage-done word, in the cycle after the token. Later tokens, and tokens to endpoints with nothing pending, write nothing.
- R8: `setup_irq[e]` rises in the cycle after a pop with `fifo_pop_is_status` high of the stage-done word for endpoint e. Popping a SETUP-data status word does not raise it. Writing 1 to `irq_clr[e]` clears it, and a set wins.
- R9: `out_ep_en[e]` is set by `out_en_set[e]`. It is low in the cycle the stage-done word for endpoint e is written, and a clear wins over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN |
| tok_ep | input | EP_W | Token endpoint number |
| rx_byte_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | 32 | Receive FIFO write word |
| fifo_pop | input | 1 | Application popped a word |
| fifo_pop_is_status | input | 1 | Popped word is a status word |
| fifo_pop_data | input | 32 | Popped word |
| cnt_wr_en | input | NUM_EP | Per-endpoint counter load |
| cnt_wr_val | input | CNT_W | Counter load value |
| setup_cnt | output | NUM_EP*CNT_W | Counter readback |
| in_nak | output | NUM_EP | IN NAK flags |
| out_nak | output | NUM_EP | OUT NAK flags |
| nak_in_clr | input | NUM_EP | IN NAK clear |
| nak_out_clr | input | NUM_EP | OUT NAK clear |
| out_ep_en | output | NUM_EP | OUT endpoint enables |
| out_en_set | input | NUM_EP | OUT enable set |
| setup_irq | output | NUM_EP | SETUP interrupt flags |
| irq_clr | input | NUM_EP | Write-1-to-clear for setup_irq |

## Verification
A wrong byte index or sequencer state shows at the FIFO port within the three write cycles that follow the eighth byte. It appears as a misplaced, missing or extra word. A stale pending flag appears at the next IN or OUT token, as a spurious or missing stage-done word on the following cycle. Counter, NAK, enable and interrupt faults appear on their outputs one cycle after the causing edge. The bench samples each of these one cycle after that edge and again later, to catch flags that fail to hold.

// File: rtl/usb_setup_pkg.sv
package usb_setup_pkg;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_OUT   = 2'd1,
        TOK_IN    = 2'd2
    } tok_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_COLLECT,
        SQ_W_STAT,
        SQ_W_D0,
        SQ_W_D1,
        SQ_W_DONE
    } seq_state_e;

    localparam logic [3:0]  CODE_SETUP_DATA = 4'h6;
    localparam logic [3:0]  CODE_STAGE_DONE = 4'h4;
    localparam logic [10:0] SETUP_BYTES     = 11'd8;

    function automatic logic [31:0] status_word(input logic [3:0]  ep,
                                                input logic [10:0] bcnt,
                                                input logic [3:0]  code);
        logic [31:0] w;
        w        = '0;
        w[3:0]   = ep;
        w[14:4]  = bcnt;
        w[20:17] = code;
        return w;
    endfunction

endpackage

// File: rtl/usb_setup_fsm.sv
module usb_setup_fsm
    import usb_setup_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic [NUM_EP-1:0] ep_pending,
    output logic              fifo_wr_en,
    output logic [31:0]       fifo_wr_data,
    output logic              setup_pulse,
    output logic              stage_pulse,
    output logic [EP_W-1:0]   cur_ep,
    output logic              emit_stat,
    output logic              emit_done
);

    typedef struct packed {
        seq_state_e      state;
        logic [EP_W-1:0] ep;
        logic [2:0]      idx;
        logic [63:0]     payload;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d           = q;
        setup_pulse = 1'b0;
        stage_pulse = 1'b0;
        case (q.state)
            SQ_IDLE: begin
                if (tok_valid) begin
                    if (tok_kind == TOK_SETUP) begin
                        d.state = SQ_COLLECT;
                        d.ep    = tok_ep;
                        d.idx   = '0;
                    end else if ((tok_kind == TOK_OUT || tok_kind == TOK_IN)
                                 && ep_pending[tok_ep]) begin
                        d.state     = SQ_W_DONE;
                        d.ep        = tok_ep;
                        stage_pulse = 1'b1;
                    end
                end
            end
            SQ_COLLECT: begin
                if (rx_byte_valid) begin
                    d.payload[{q.idx, 3'b000} +: 8] = rx_byte;
                    d.idx = q.idx + 3'd1;
                    if (q.idx == 3'd7) begin
                        d.state     = SQ_W_STAT;
                        setup_pulse = 1'b1;
                    end
                end
            end
            SQ_W_STAT: d.state = SQ_W_D0;
            SQ_W_D0:   d.state = SQ_W_D1;
            SQ_W_D1:   d.state = SQ_IDLE;
            SQ_W_DONE: d.state = SQ_IDLE;
            default:   d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= SQ_IDLE;
            q.ep      <= '0;
            q.idx     <= '0;
            q.payload <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        fifo_wr_en   = 1'b1;
        fifo_wr_data = '0;
        case (q.state)
            SQ_W_STAT: fifo_wr_data = status_word(4'(q.ep), SETUP_BYTES, CODE_SETUP_DATA);
            SQ_W_D0:   fifo_wr_data = q.payload[31:0];
            SQ_W_D1:   fifo_wr_data = q.payload[63:32];
            SQ_W_DONE: fifo_wr_data = status_word(4'(q.ep), 11'd0, CODE_STAGE_DONE);
            default:   fifo_wr_en   = 1'b0;
        endcase
    end

    assign cur_ep    = q.ep;
    assign emit_stat = (q.state == SQ_W_STAT);
    assign emit_done = (q.state == SQ_W_DONE);

endmodule

// File: rtl/usb_setup_ep_slot.sv
module usb_setup_ep_slot #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic             setup_hit,
    input  logic             stage_hit,
    input  logic             pop_hit,
    input  logic             nak_in_clr,
    input  logic             nak_out_clr,
    input  logic             out_en_set,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             in_nak,
    output logic             out_nak,
    output logic             out_en,
    output logic             irq,
    output logic             pending
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             in_nak;
        logic             out_nak;
        logic             out_en;
        logic             irq;
        logic             pending;
    } slot_t;

    slot_t q, d;

    always_comb begin
        d = q;
        if (cfg_wr)      d.cnt     = cfg_val;
        if (setup_hit)   d.cnt     = d.cnt - CNT_W'(1);
        if (nak_in_clr)  d.in_nak  = 1'b0;
        if (nak_out_clr) d.out_nak = 1'b0;
        if (setup_hit) begin
            d.in_nak  = 1'b1;
            d.out_nak = 1'b1;
            d.pending = 1'b1;
        end
        if (out_en_set)  d.out_en  = 1'b1;
        if (stage_hit) begin
            d.out_en  = 1'b0;
            d.pending = 1'b0;
        end
        if (irq_clr)     d.irq     = 1'b0;
        if (pop_hit)     d.irq     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt     = q.cnt;
    assign in_nak  = q.in_nak;
    assign out_nak = q.out_nak;
    assign out_en  = q.out_en;
    assign irq     = q.irq;
    assign pending = q.pending;

endmodule

// File: rtl/usb_setup_rx_seq.sv
module usb_setup_rx_seq
    import usb_setup_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int CNT_W  = 2,
    parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tok_valid,
    input  logic [1:0]              tok_kind,
    input  logic [EP_W-1:0]         tok_ep,
    input  logic                    rx_byte_valid,
    input  logic [7:0]              rx_byte,
    output logic                    fifo_wr_en,
    output logic [31:0]             fifo_wr_data,
    input  logic                    fifo_pop,
    input  logic                    fifo_pop_is_status,
    input  logic [31:0]             fifo_pop_data,
    input  logic [NUM_EP-1:0]       cnt_wr_en,
    input  logic [CNT_W-1:0]        cnt_wr_val,
    output logic [NUM_EP*CNT_W-1:0] setup_cnt,
    output logic [NUM_EP-1:0]       in_nak,
    output logic [NUM_EP-1:0]       out_nak,
    input  logic [NUM_EP-1:0]       nak_in_clr,
    input  logic [NUM_EP-1:0]       nak_out_clr,
    output logic [NUM_EP-1:0]       out_ep_en,
    input  logic [NUM_EP-1:0]       out_en_set,
    output logic [NUM_EP-1:0]       setup_irq,
    input  logic [NUM_EP-1:0]       irq_clr
);

    localparam logic [27:0] DONE_TAG = 28'(status_word(4'h0, 11'd0, CODE_STAGE_DONE) >> 4);

    logic              setup_pulse;
    logic              stage_pulse;
    logic [EP_W-1:0]   cur_ep;
    logic              emit_stat;
    logic              emit_done;
    logic [NUM_EP-1:0] ep_pending;
    logic              done_pop;

    assign done_pop = fifo_pop && fifo_pop_is_status && (fifo_pop_data[31:4] == DONE_TAG);

    usb_setup_fsm #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tok_valid    (tok_valid),
        .tok_kind     (tok_kind),
        .tok_ep       (tok_ep),
        .rx_byte_valid(rx_byte_valid),
        .rx_byte      (rx_byte),
        .ep_pending   (ep_pending),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .setup_pulse  (setup_pulse),
        .stage_pulse  (stage_pulse),
        .cur_ep       (cur_ep),
        .emit_stat    (emit_stat),
        .emit_done    (emit_done)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
        usb_setup_ep_slot #(.CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr     (cnt_wr_en[g]),
            .cfg_val    (cnt_wr_val),
            .setup_hit  (setup_pulse && (cur_ep == EP_W'(g))),
            .stage_hit  (stage_pulse && (tok_ep == EP_W'(g))),
            .pop_hit    (done_pop && (fifo_pop_data[3:0] == 4'(g))),
            .nak_in_clr (nak_in_clr[g]),
            .nak_out_clr(nak_out_clr[g]),
            .out_en_set (out_en_set[g]),
            .irq_clr    (irq_clr[g]),
            .cnt        (setup_cnt[g*CNT_W +: CNT_W]),
            .in_nak     (in_nak[g]),
            .out_nak    (out_nak[g]),
            .out_en     (out_ep_en[g]),
            .irq        (setup_irq[g]),
            .pending    (ep_pending[g])
        );
    end

endmodule

// File: rtl/usb_setup_rx_chk.sv
module usb_setup_rx_chk #(
    parameter int NUM_EP = 4,
    parameter int CNT_W  = 2,
    parameter int EP_W   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fifo_wr_en,
    input logic                    fifo_pop,
    input logic                    fifo_pop_is_status,
    input logic [NUM_EP-1:0]       cnt_wr_en,
    input logic [NUM_EP*CNT_W-1:0] setup_cnt,
    input logic [NUM_EP-1:0]       in_nak,
    input logic [NUM_EP-1:0]       out_nak,
    input logic [NUM_EP-1:0]       out_ep_en,
    input logic [NUM_EP-1:0]       setup_irq,
    input logic                    setup_pulse,
    input logic [EP_W-1:0]         cur_ep,
    input logic                    emit_stat,
    input logic                    emit_done
);

    logic [NUM_EP-1:0] ep_mask;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  cnt_expect_q;

    assign ep_mask = NUM_EP'(1) << cur_ep;
    assign cur_cnt = setup_cnt[cur_ep*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
        cnt_expect_q <= cur_cnt - CNT_W'(1);
    end

    AST_SETUP_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        emit_stat |=> fifo_wr_en ##1 fifo_wr_en);                                        // R3
    AST_NAK_BOTH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        setup_pulse |=> ((in_nak & out_nak & $past(ep_mask)) == $past(ep_mask)));        // R5
    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_pulse && cnt_wr_en == '0) |=> (cur_cnt == cnt_expect_q));                 // R1
    AST_IRQ_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(setup_irq & ~$past(setup_irq))) |-> $past(fifo_pop && fifo_pop_is_status));   // R8
    AST_DONE_DISABLES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        emit_done |-> ((out_ep_en & ep_mask) == '0));                                     // R9
    AST_SINGLE_DONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        emit_done |=> !emit_done);                                                        // R7

endmodule

bind usb_setup_rx_seq usb_setup_rx_chk #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .EP_W(EP_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .fifo_wr_en        (fifo_wr_en),
    .fifo_pop          (fifo_pop),
    .fifo_pop_is_status(fifo_pop_is_status),
    .cnt_wr_en         (cnt_wr_en),
    .setup_cnt         (setup_cnt),
    .in_nak            (in_nak),
    .out_nak           (out_nak),
    .out_ep_en         (out_ep_en),
    .setup_irq         (setup_irq),
    .setup_pulse       (setup_pulse),
    .cur_ep            (cur_ep),
    .emit_stat         (emit_stat),
    .emit_done         (emit_done)
);

// File: tb/usb_setup_rx_seq_tb.sv
module usb_setup_rx_seq_tb;

    localparam int NEP = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tok_valid = 1'b0;
    logic [1:0]     tok_kind = 2'd0;
    logic [1:0]     tok_ep = 2'd0;
    logic           rx_byte_valid = 1'b0;
    logic [7:0]     rx_byte = 8'd0;
    logic           fifo_wr_en;
    logic [31:0]    fifo_wr_data;
    logic           fifo_pop = 1'b0;
    logic           fifo_pop_is_status = 1'b0;
    logic [31:0]    fifo_pop_data = 32'd0;
    logic [NEP-1:0] cnt_wr_en = '0;
    logic [1:0]     cnt_wr_val = 2'd0;
    logic [2*NEP-1:0] setup_cnt;
    logic [NEP-1:0] in_nak, out_nak, out_ep_en, setup_irq;
    logic [NEP-1:0] nak_in_clr = '0, nak_out_clr = '0, out_en_set = '0, irq_clr = '0;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    usb_setup_rx_seq #(.NUM_EP(NEP)) u_dut (.*);

    function automatic logic [31:0] sts(input int ep, input int bcnt, input logic [3:0] code);
        return (32'(code) << 17) | (32'(bcnt) << 4) | 32'(ep);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 reset counters", 32'(setup_cnt), 32'd0);
        chk_eq("R5 reset nak", {in_nak, out_nak}, 32'd0);
        chk_eq("R9 reset enable", 32'(out_ep_en), 32'd0);
        chk_eq("R8 reset irq", 32'(setup_irq), 32'd0);
        chk_eq("R3 reset no write", 32'(fifo_wr_en), 32'd0);
    endtask

    task automatic load_cnt(input int ep, input logic [1:0] v);
        @(negedge clk);
        cnt_wr_en[ep] = 1'b1; cnt_wr_val = v;
        @(negedge clk);
        cnt_wr_en = '0;
        chk_eq("R1 counter load", 32'(setup_cnt[ep*2 +: 2]), 32'(v));
    endtask

    task automatic send_setup(input int ep, input logic [63:0] pl, input logic [1:0] exp_cnt, input string tag);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = 2'd0; tok_ep = 2'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rx_byte_valid = 1'b1; rx_byte = pl[i*8 +: 8];
            @(negedge clk);
        end
        rx_byte_valid = 1'b0;
        chk_eq({tag, " R3 status write"}, 32'(fifo_wr_en), 32'd1);
        chk_eq({tag, " R4 status word"}, fifo_wr_data, sts(ep, 8, 4'h6));
        chk_eq({tag, " R1 counter"}, 32'(setup_cnt[ep*2 +: 2]), 32'(exp_cnt));
        chk_eq({tag, " R5 nak pair"}, {30'd0, in_nak[ep], out_nak[ep]}, 32'd3);
        @(negedge clk);
        chk_eq({tag, " R3 word bytes 0-3"}, {31'd0, fifo_wr_en} == 32'd1 ? fifo_wr_data : 32'hx, pl[31:0]);
        @(negedge clk);
        chk_eq({tag, " R3 word bytes 4-7"}, {31'd0, fifo_wr_en} == 32'd1 ? fifo_wr_data : 32'hx, pl[63:32]);
        @(negedge clk);
        chk_eq({tag, " R3 burst ends"}, 32'(fifo_wr_en), 32'd0);
    endtask

    task automatic send_token(input logic [1:0] kind, input int ep, input bit exp_wr, input string tag);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = kind; tok_ep = 2'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        chk_eq({tag, " R7 write strobe"}, 32'(fifo_wr_en), 32'(exp_wr));
        if (exp_wr) begin
            chk_eq({tag, " R4 stage-done word"}, fifo_wr_data, sts(ep, 0, 4'h4));
            chk_eq({tag, " R9 enable cleared"}, 32'(out_ep_en[ep]), 32'd0);
        end
        @(negedge clk);
        chk_eq({tag, " R7 single word"}, 32'(fifo_wr_en), 32'd0);
    endtask

    task automatic pop_word(input logic [31:0] w, input bit is_sts);
        @(negedge clk);
        fifo_pop = 1'b1; fifo_pop_is_status = is_sts; fifo_pop_data = w;
        @(negedge clk);
        fifo_pop = 1'b0; fifo_pop_is_status = 1'b0;
    endtask

    task automatic t_basic;
        load_cnt(0, 2'd3);
        @(negedge clk); out_en_set = 4'b0001; @(negedge clk); out_en_set = '0;
        chk_eq("R9 enable set", 32'(out_ep_en), 32'd1);
        send_setup(0, 64'h0706050403020100, 2'd2, "basic");
    endtask

    task automatic t_back_to_back;
        send_setup(0, 64'hDEADBEEF_12345678, 2'd1, "b2b1 R6");
        send_setup(0, 64'h00FF00FF_A5A55A5A, 2'd0, "b2b2 R6");
        send_setup(0, 64'h1122334455667788, 2'd3, "b2b3 R2 wrap");
    endtask

    task automatic t_unprogrammed;
        send_setup(2, 64'hCAFEF00D_0BADC0DE, 2'd3, "unprog R2");
        chk_eq("R5 other ep untouched", 32'(in_nak[1]), 32'd0);
    endtask

    task automatic t_stage;
        send_token(2'd2, 1, 1'b0, "no pending ep1");
        send_token(2'd1, 0, 1'b1, "out ep0");
        send_token(2'd2, 0, 1'b0, "second token ep0");
        send_token(2'd2, 2, 1'b1, "in ep2");
    endtask

    task automatic t_irq;
        pop_word(sts(0, 8, 4'h6), 1'b1);
        chk_eq("R8 setup status pop ignored", 32'(setup_irq), 32'd0);
        pop_word(sts(0, 0, 4'h4), 1'b1);
        chk_eq("R8 irq on done pop", 32'(setup_irq), 32'd1);
        repeat (3) @(negedge clk);
        chk_eq("R8 irq holds", 32'(setup_irq), 32'd1);
        @(negedge clk); irq_clr = 4'b0001; @(negedge clk); irq_clr = '0;
        chk_eq("R8 irq cleared", 32'(setup_irq), 32'd0);
        pop_word(sts(2, 0, 4'h4), 1'b1);
        chk_eq("R8 irq ep2", 32'(setup_irq), 32'd4);
    endtask

    task automatic t_nak_clear;
        repeat (4) @(negedge clk);
        chk_eq("R5 nak holds", {in_nak[0], out_nak[0]}, 32'd3);
        @(negedge clk); nak_in_clr = 4'b0001; @(negedge clk); nak_in_clr = '0;
        chk_eq("R5 in nak cleared only", {in_nak[0], out_nak[0]}, 32'd1);
        @(negedge clk); nak_out_clr = 4'b0001; @(negedge clk); nak_out_clr = '0;
        chk_eq("R5 out nak cleared", {in_nak[0], out_nak[0]}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_back_to_back();
        t_unprogrammed();
        t_stage();
        t_irq();
        t_nak_clear();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule